// File: doc/BRIEF.md
# Tank Macro-Task Sequence Controller

This block runs one macro-task of a batch plant as its own small sequencer. A supervisor arbitrates the shared tanks and then sends a single-cycle begin pulse. The controller drives the plant actuators through a fixed series of steps. Each step ends either on a level or temperature sensor or after a minimum time. When the last step is complete, the controller returns a single-cycle end pulse to the supervisor. It performs no resource checks of its own and exchanges no signals with peer controllers.

One parameter selects which operation an instance performs. The load-and-wait style fills with two materials and then dwells. The load-and-heat style fills with one material and then heats. The transfer style pumps a tank out to the reactor. The reactor style adds the reactant, mixes and then drains. Minimum times are counted in pulses of a tick-enable input, so the time base comes from outside the block. The two limits are parameters, with defaults of 30 ticks for the dwell and 60 ticks for the mix.

Top module: `mtask_seq`

## Requirements
- R1: While reset is low, and in the idle state, every actuator output and `task_done` are 0. A synchronous reset returns the block to idle from any step.
- R2: In idle, a begin pulse sampled at a clock edge enters the first step of the selected style at that edge. Without a begin pulse the block stays idle, whatever the sensors show.
- R3: Each accepted begin produces exactly one `task_done` pulse. The pulse is one cycle long. It comes in the cycle after the final step's exit condition is sampled. The block is idle in the cycle after the pulse.
- R4: A begin pulse that arrives while the block is busy has no effect. This includes the cycle in which `task_done` is high.
- R5: Load-and-wait style (`MODE_LOAD_WAIT`): `mat_a_open` and `mat_b_open` are both high until `lvl_high` is sampled. A dwell step follows with all actuators low.
- R6: A timed step (dwell or mix) counts `tick_en` pulses from the edge that entered it. It leaves at the first edge after the count reaches its limit (`HOLD_TICKS` or `MIX_TICKS`). The edge that enters the step does not count.
- R7: Load-and-heat style (`MODE_LOAD_HEAT`): `mat_a_open` is high until `lvl_high` is sampled. After that, `heater_on` is high until `temp_reached` is sampled, and then the end pulse follows.
- R8: Transfer style (`MODE_TRANSFER`): `pump_on` is high until `lvl_low` is sampled, and then the end pulse follows.
- R9: Reactor style (`MODE_REACT_MIX`): `reactant_open` is high until `lvl_high` is sampled. `mixer_on` is then high for a timed step of `MIX_TICKS`. Finally `outlet_open` is high until `lvl_low` is sampled.
- R10: A sensor input affects only the step that watches it. In every other step and in idle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| task_go | input | 1 | Begin pulse from the supervisor |
| tick_en | input | 1 | Time-base pulse for the minimum-duration steps |
| lvl_high | input | 1 | Tank high-level sensor |
| lvl_low | input | 1 | Tank low-level sensor |
| temp_reached | input | 1 | Target temperature reached flag |
| task_done | output | 1 | End pulse to the supervisor |
| mat_a_open | output | 1 | First material inlet valve |
| mat_b_open | output | 1 | Second material inlet valve |
| reactant_open | output | 1 | Reactant inlet valve |
| heater_on | output | 1 | Heater command |
| pump_on | output | 1 | Output pump command |
| mixer_on | output | 1 | Mixer command |
| outlet_open | output | 1 | Outlet valve |

## Verification
The assertions assume that `task_go` is a clean synchronous pulse and that the supervisor has already granted every resource. Under those conditions, any begin received while busy must leave the step sequence unchanged. They also assume that the timed-step limits are at least one, so a timed step can never end on its entry edge. The bench drives sensors only as synchronous levels changed between clock edges, with `task_go` held for exactly one cycle. It varies the `tick_en` spacing between one and three cycles, so the minimum-time checks hold for sparse as well as dense ticks.

// File: rtl/mtask_pkg.sv
// Shared types for the macro-task sequencer.
// Assumes: nothing; pure type definitions.
package mtask_pkg;

    // Operation style selected per instance.
    typedef enum logic [1:0] {
        MODE_LOAD_WAIT,
        MODE_LOAD_HEAT,
        MODE_TRANSFER,
        MODE_REACT_MIX
    } mode_e;

    // Steps of the sequence; each style visits a subset.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_HOLD,
        ST_HEAT,
        ST_PUMP,
        ST_MIX,
        ST_DRAIN,
        ST_END
    } step_e;

    // Actuator command bundle.
    typedef struct packed {
        logic mat_a;
        logic mat_b;
        logic reactant;
        logic heater;
        logic pump;
        logic mixer;
        logic outlet;
    } act_t;

endpackage

// File: rtl/mtask_timer.sv
// Minimum-duration timer: counts tick pulses since the last clear and
// flags when the count equals the limit, saturating there.
// Assumes: limit is constant between clears; clear coincides with step entry.
module mtask_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Tick counter, cleared on step change, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick_en && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry flag for the step sequencer.
    always_comb expired = (cnt_q == limit);

    // Count never passes the limit of the running step (R6).
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // Without a tick or a clear the count does not move (R6).
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick_en) |=> $stable(cnt_q));

endmodule

// File: rtl/mtask_steps.sv
// Step sequencer: moves through the steps of the selected style on the
// begin pulse, sensor levels and timer expiry.
// Assumes: resources were granted upstream; task_go is a one-cycle pulse.
module mtask_steps
    import mtask_pkg::*;
#(
    parameter mode_e MODE = MODE_REACT_MIX
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  task_go,
    input  logic  lvl_high,
    input  logic  lvl_low,
    input  logic  temp_reached,
    input  logic  tmr_expired,
    output step_e step_q,
    output logic  tmr_clr
);

    localparam step_e FIRST_STEP = (MODE == MODE_TRANSFER) ? ST_PUMP : ST_FILL;

    step_e step_d;

    // Next-step decision for the selected style.
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE:  if (task_go) step_d = FIRST_STEP;
            ST_FILL: begin
                if (lvl_high) begin
                    unique case (MODE)
                        MODE_LOAD_WAIT: step_d = ST_HOLD;
                        MODE_LOAD_HEAT: step_d = ST_HEAT;
                        MODE_REACT_MIX: step_d = ST_MIX;
                        default:        step_d = ST_END;
                    endcase
                end
            end
            ST_HOLD:  if (tmr_expired)  step_d = ST_END;
            ST_HEAT:  if (temp_reached) step_d = ST_END;
            ST_PUMP:  if (lvl_low)      step_d = ST_END;
            ST_MIX:   if (tmr_expired)  step_d = ST_DRAIN;
            ST_DRAIN: if (lvl_low)      step_d = ST_END;
            ST_END:                     step_d = ST_IDLE;
            default:                    step_d = ST_IDLE;
        endcase
    end

    // Step register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    // Timer restarts whenever a new step is entered.
    always_comb tmr_clr = (step_d != step_q);

    // No start without a begin pulse (R2).
    p_idle_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_IDLE && !task_go) |=> (step_q == ST_IDLE));

    // A busy block never falls back to idle except through the end step (R4).
    p_busy_ignores_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != ST_IDLE && step_q != ST_END) |=> (step_q != ST_IDLE));

    // Timed steps only leave once the timer has expired (R6).
    p_hold_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_HOLD && step_d != ST_HOLD) |-> tmr_expired);
    p_mix_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_MIX && step_d != ST_MIX) |-> tmr_expired);

endmodule

// File: rtl/mtask_drive.sv
// Actuator decode: maps the current step and style onto plant commands.
// Assumes: step comes from a register, so outputs are glitch-free per cycle.
module mtask_drive
    import mtask_pkg::*;
#(
    parameter mode_e MODE = MODE_REACT_MIX
) (
    input  step_e step_q,
    output act_t  act,
    output logic  done
);

    // One actuator group per step; the fill valves depend on the style.
    always_comb begin
        act = '0;
        unique case (step_q)
            ST_FILL: begin
                act.mat_a    = (MODE == MODE_LOAD_WAIT) || (MODE == MODE_LOAD_HEAT);
                act.mat_b    = (MODE == MODE_LOAD_WAIT);
                act.reactant = (MODE == MODE_REACT_MIX);
            end
            ST_HEAT:  act.heater = 1'b1;
            ST_PUMP:  act.pump   = 1'b1;
            ST_MIX:   act.mixer  = 1'b1;
            ST_DRAIN: act.outlet = 1'b1;
            default:  act = '0;
        endcase
    end

    // End pulse lasts exactly the single end step.
    always_comb done = (step_q == ST_END);

endmodule

// File: rtl/mtask_seq.sv
// Macro-task sequence controller top: step sequencer, minimum-time timer
// and actuator decode for one operation style chosen by MODE.
// Assumes: supervisor has granted all resources; tick_en is a one-cycle
// time-base strobe; HOLD_TICKS and MIX_TICKS are at least 1.
module mtask_seq
    import mtask_pkg::*;
#(
    parameter mode_e MODE       = MODE_REACT_MIX,
    parameter int    HOLD_TICKS = 30,
    parameter int    MIX_TICKS  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic task_go,
    input  logic tick_en,
    input  logic lvl_high,
    input  logic lvl_low,
    input  logic temp_reached,
    output logic task_done,
    output logic mat_a_open,
    output logic mat_b_open,
    output logic reactant_open,
    output logic heater_on,
    output logic pump_on,
    output logic mixer_on,
    output logic outlet_open
);

    localparam int TMAX = (HOLD_TICKS > MIX_TICKS) ? HOLD_TICKS : MIX_TICKS;
    localparam int TW   = $clog2(TMAX + 1);

    step_e         step_q;
    logic          tmr_clr;
    logic          tmr_expired;
    logic [TW-1:0] tmr_limit;
    act_t          act;

    // Limit of the running timed step.
    always_comb tmr_limit = (step_q == ST_MIX) ? TW'(MIX_TICKS) : TW'(HOLD_TICKS);

    mtask_steps #(.MODE(MODE)) u_steps (
        .clk          (clk),
        .rst_n        (rst_n),
        .task_go      (task_go),
        .lvl_high     (lvl_high),
        .lvl_low      (lvl_low),
        .temp_reached (temp_reached),
        .tmr_expired  (tmr_expired),
        .step_q       (step_q),
        .tmr_clr      (tmr_clr)
    );

    mtask_timer #(.CNT_W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick_en (tick_en),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    mtask_drive #(.MODE(MODE)) u_drive (
        .step_q (step_q),
        .act    (act),
        .done   (task_done)
    );

    // Unpack the actuator bundle onto the plant pins.
    always_comb begin
        mat_a_open    = act.mat_a;
        mat_b_open    = act.mat_b;
        reactant_open = act.reactant;
        heater_on     = act.heater;
        pump_on       = act.pump;
        mixer_on      = act.mixer;
        outlet_open   = act.outlet;
    end

    // Idle means every actuator is off (R1).
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_IDLE) |-> (act == '0 && !task_done));

    // End pulse is a single cycle (R3).
    p_end_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        task_done |=> !task_done);

    // End pulse is followed by idle (R3).
    p_end_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        task_done |=> (step_q == ST_IDLE));

    // At most one actuator group is active at a time (R5).
    p_one_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({act.mat_a | act.mat_b | act.reactant, act.heater,
                    act.pump, act.mixer, act.outlet}) <= 1);

endmodule

// File: tb/mtask_seq_bench.sv
// Bench: one instance per operation style, swept over sensor delays and
// tick spacings; expected outputs come from the requirement text.
module mtask_seq_bench;
    import mtask_pkg::*;

    localparam int HOLD_T = 4;
    localparam int MIX_T  = 6;
    // Output vector bits: {mat_a, mat_b, reactant, heater, pump, mixer, outlet, done}
    localparam logic [7:0] B_A = 8'h80, B_B = 8'h40, B_R = 8'h20, B_H = 8'h10;
    localparam logic [7:0] B_P = 8'h08, B_M = 8'h04, B_O = 8'h02, B_D = 8'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] go = '0;
    logic tick_en = 1'b0, lvl_high = 1'b0, lvl_low = 1'b0, temp_reached = 1'b0;
    logic [7:0] o_mix, o_wait, o_heat, o_xfer;
    int vectors = 0, miscompares = 0;
    int tick_per = 1, tick_ph = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mtask_seq #(.MODE(MODE_REACT_MIX), .HOLD_TICKS(HOLD_T), .MIX_TICKS(MIX_T)) u_mtask_seq (
        .clk(clk), .rst_n(rst_n), .task_go(go[0]), .tick_en(tick_en),
        .lvl_high(lvl_high), .lvl_low(lvl_low), .temp_reached(temp_reached),
        .task_done(o_mix[0]), .mat_a_open(o_mix[7]), .mat_b_open(o_mix[6]),
        .reactant_open(o_mix[5]), .heater_on(o_mix[4]), .pump_on(o_mix[3]),
        .mixer_on(o_mix[2]), .outlet_open(o_mix[1]));

    mtask_seq #(.MODE(MODE_LOAD_WAIT), .HOLD_TICKS(HOLD_T), .MIX_TICKS(MIX_T)) u_mtask_seq_wait (
        .clk(clk), .rst_n(rst_n), .task_go(go[1]), .tick_en(tick_en),
        .lvl_high(lvl_high), .lvl_low(lvl_low), .temp_reached(temp_reached),
        .task_done(o_wait[0]), .mat_a_open(o_wait[7]), .mat_b_open(o_wait[6]),
        .reactant_open(o_wait[5]), .heater_on(o_wait[4]), .pump_on(o_wait[3]),
        .mixer_on(o_wait[2]), .outlet_open(o_wait[1]));

    mtask_seq #(.MODE(MODE_LOAD_HEAT), .HOLD_TICKS(HOLD_T), .MIX_TICKS(MIX_T)) u_mtask_seq_heat (
        .clk(clk), .rst_n(rst_n), .task_go(go[2]), .tick_en(tick_en),
        .lvl_high(lvl_high), .lvl_low(lvl_low), .temp_reached(temp_reached),
        .task_done(o_heat[0]), .mat_a_open(o_heat[7]), .mat_b_open(o_heat[6]),
        .reactant_open(o_heat[5]), .heater_on(o_heat[4]), .pump_on(o_heat[3]),
        .mixer_on(o_heat[2]), .outlet_open(o_heat[1]));

    mtask_seq #(.MODE(MODE_TRANSFER), .HOLD_TICKS(HOLD_T), .MIX_TICKS(MIX_T)) u_mtask_seq_xfer (
        .clk(clk), .rst_n(rst_n), .task_go(go[3]), .tick_en(tick_en),
        .lvl_high(lvl_high), .lvl_low(lvl_low), .temp_reached(temp_reached),
        .task_done(o_xfer[0]), .mat_a_open(o_xfer[7]), .mat_b_open(o_xfer[6]),
        .reactant_open(o_xfer[5]), .heater_on(o_xfer[4]), .pump_on(o_xfer[3]),
        .mixer_on(o_xfer[2]), .outlet_open(o_xfer[1]));

    function automatic logic [7:0] outv(input int sel);
        case (sel)
            0:       return o_mix;
            1:       return o_wait;
            2:       return o_heat;
            default: return o_xfer;
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_i(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance one clock; inputs change at the falling edge, tick spaced by tick_per.
    task automatic cyc();
        @(negedge clk);
        tick_ph++;
        tick_en = ((tick_ph % tick_per) == 0);
    endtask

    // Follow a timed step and check its tick count from entry (R6).
    task automatic timed(input int sel, input logic [7:0] in_step, input int limit, input string tag);
        int cnt = 0;
        int guard = 0;
        logic t;
        logic t_prev = 1'b0;
        while (outv(sel) == in_step && guard < 400) begin
            t = tick_en;
            cyc();
            guard++;
            if (outv(sel) == in_step) begin
                if (t) cnt++;
                t_prev = t;
            end
        end
        chk_i(cnt, limit, {tag, " R6 ticks counted in step"});
        chk_i(int'(t_prev), 1, {tag, " R6 exit right after last tick"});
    endtask

    task automatic run_react(input int fd, input int dd);
        lvl_high = 0; lvl_low = 0; temp_reached = 0;
        chk(o_mix, 8'h00, "R1 react idle");
        go[0] = 1; cyc(); go[0] = 0;
        chk(o_mix, B_R, "R2 R9 reactant fill start");
        lvl_low = 1;  // low level must not end the fill (R10)
        for (int i = 0; i < fd; i++) begin
            cyc(); chk(o_mix, B_R, "R10 R9 fill ignores lvl_low");
        end
        lvl_high = 1; cyc(); lvl_high = 0;
        chk(o_mix, B_M, "R9 mixer after high level");
        timed(0, B_M, MIX_T, "R9 mix");
        chk(o_mix, B_O, "R9 outlet after mix");
        lvl_low = 0;
        go[0] = 1; cyc(); go[0] = 0;
        chk(o_mix, B_O, "R4 begin ignored while draining");
        for (int i = 0; i < dd; i++) begin
            cyc(); chk(o_mix, B_O, "R9 outlet until low level");
        end
        lvl_low = 1; cyc(); lvl_low = 0;
        chk(o_mix, B_D, "R3 react end pulse");
        go[0] = 1; cyc(); go[0] = 0;
        chk(o_mix, 8'h00, "R4 begin ignored in end cycle");
        cyc(); chk(o_mix, 8'h00, "R3 single end pulse");
    endtask

    task automatic run_wait(input int fd);
        lvl_high = 0; lvl_low = 0; temp_reached = 0;
        go[1] = 1; cyc(); go[1] = 0;
        chk(o_wait, B_A | B_B, "R5 both valves open");
        temp_reached = 1;
        for (int i = 0; i < fd; i++) begin
            cyc(); chk(o_wait, B_A | B_B, "R5 R10 fill until high level");
        end
        lvl_high = 1; cyc(); lvl_high = 0;
        chk(o_wait, 8'h00, "R5 dwell with valves closed");
        timed(1, 8'h00, HOLD_T, "R5 dwell");
        chk(o_wait, B_D, "R3 wait end pulse");
        temp_reached = 0;
        cyc(); chk(o_wait, 8'h00, "R3 wait back to idle");
    endtask

    task automatic run_heat(input int fd, input int hd, input bit early);
        lvl_high = 0; lvl_low = 0; temp_reached = early;
        go[2] = 1; cyc(); go[2] = 0;
        chk(o_heat, B_A, "R7 material valve open");
        for (int i = 0; i < fd; i++) begin
            cyc(); chk(o_heat, B_A, "R7 R10 fill ignores temperature");
        end
        lvl_high = 1; cyc(); lvl_high = 0;
        chk(o_heat, B_H, "R7 heater after high level");
        if (!early) begin
            for (int i = 0; i < hd; i++) begin
                cyc(); chk(o_heat, B_H, "R7 heater until temperature");
            end
            temp_reached = 1;
        end
        cyc(); temp_reached = 0;
        chk(o_heat, B_D, "R3 R7 heat end pulse");
        cyc(); chk(o_heat, 8'h00, "R3 heat back to idle");
    endtask

    task automatic run_xfer(input int ld, input bit pre);
        lvl_high = 1; lvl_low = 1; temp_reached = 1;
        cyc(); cyc();
        chk(o_xfer, 8'h00, "R10 R2 sensors ignored in idle");
        lvl_high = 0; temp_reached = 0; lvl_low = pre;
        go[3] = 1; cyc(); go[3] = 0;
        chk(o_xfer, B_P, "R8 pump on");
        if (!pre) begin
            for (int i = 0; i < ld; i++) begin
                cyc(); chk(o_xfer, B_P, "R8 pump until low level");
            end
            lvl_low = 1;
        end
        cyc(); lvl_low = 0;
        chk(o_xfer, B_D, "R3 R8 transfer end pulse");
        cyc(); chk(o_xfer, 8'h00, "R3 transfer back to idle");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset with begin and all sensors asserted (R1).
        go = '1; lvl_high = 1; lvl_low = 1; temp_reached = 1;
        repeat (3) cyc();
        chk(o_mix | o_wait | o_heat | o_xfer, 8'h00, "R1 outputs low in reset");
        go = '0; lvl_high = 0; lvl_low = 0; temp_reached = 0;
        rst_n = 1;
        cyc();
        chk(o_mix | o_wait | o_heat | o_xfer, 8'h00, "R1 idle after reset");

        // Reset in the middle of a task returns to idle (R1).
        go[0] = 1; cyc(); go[0] = 0;
        chk(o_mix, B_R, "R2 start before mid reset");
        rst_n = 0; cyc();
        chk(o_mix, 8'h00, "R1 reset mid task");
        rst_n = 1; cyc();
        chk(o_mix, 8'h00, "R1 stays idle after mid reset");

        for (int per = 1; per <= 3; per++) begin
            tick_per = per;
            for (int fd = 0; fd <= 2; fd++)
                for (int dd = 0; dd <= 2; dd++)
                    run_react(fd, dd);
            for (int fd = 0; fd <= 3; fd++)
                run_wait(fd);
        end
        tick_per = 1;
        for (int fd = 0; fd <= 2; fd++) begin
            for (int hd = 0; hd <= 2; hd++) run_heat(fd, hd, 1'b0);
            run_heat(fd, 0, 1'b1);
        end
        for (int ld = 0; ld <= 4; ld++) run_xfer(ld, 1'b0);
        run_xfer(0, 1'b1);
        finish_run();
    end

endmodule